// File: doc/BRIEF.md
# Single-Vector Interrupt Controller

This block gathers four interrupt sources into one request line for a small CPU core. The sources are a timer overflow pulse, an edge on an external interrupt pin, a change detector on four general-purpose port pins, and a pulse that reports a finished EEPROM write. Software reaches one 8-bit control and status register. It holds a master enable, one enable per source and the flags of three sources. The EEPROM-complete flag is kept in a separate bit that is brought out as a port of its own. The CPU receives a request and a fixed vector address. It answers with a taken strobe, which clears the master enable, and a return strobe, which sets it again.

The port-change detector keeps a copy of the synchronized pin values. That copy is refreshed each time software reads the port. Any pin configured as an input that no longer matches its copy raises the port-change flag. Pins configured as outputs are ignored. The external pin and the port pins pass through two-flop synchronizers before any edge detection or comparison.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, register bits 7 down to 1 read 0, `ee_flag` is 0 and `irq_req` is low.
- R2: Register bit positions are: 7 master enable, 6 EEPROM-complete enable, 5 timer enable, 4 external-pin enable, 3 port-change enable, 2 timer flag, 1 external-pin flag, 0 port-change flag. A write loads bits 7 to 3 directly from the written data.
- R3: `irq_req` is high exactly when the master enable is set and at least one flag is set together with its own enable. The EEPROM flag is gated by bit 6.
- R4: `irq_ack` clears the master enable at the next edge and takes priority over `irq_ret` and a register write in that cycle. `irq_vec` always reads 0x0004.
- R5: `irq_ret` sets the master enable at the next edge and takes priority over a register write. A flag that is still set raises `irq_req` again at once.
- R6: Only hardware sets flags. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged.
- R7: When a hardware set and a software clear of the same flag fall in the same cycle, the flag stays set.
- R8: A one-cycle `tmr_ovf` pulse sets bit 2 at the next edge.
- R9: After synchronization, a rising edge of `ext_pin` sets bit 1 (the edge is selectable by parameter, rising by default). A falling edge does not set it.
- R10: Bit 0 is set while any pin with `port_dir` = 1 (input) differs from the value captured at the last `port_rd` strobe. Pins with `port_dir` = 0 are ignored.
- R11: An `ee_done` pulse sets `ee_flag`, and `ee_flag_clr` clears it. A set and a clear in the same cycle leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register contents |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_pins | input | 4 | Asynchronous port pins watched for change |
| port_dir | input | 4 | Per-pin direction, 1 = input |
| port_rd | input | 1 | Port read strobe, captures the comparison value |
| ee_done | input | 1 | EEPROM write-complete pulse |
| ee_flag_clr | input | 1 | Software clear of the EEPROM-complete flag |
| ee_flag | output | 1 | EEPROM-complete flag |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 13 | Fixed vector address |
| irq_ack | input | 1 | CPU has taken the interrupt |
| irq_ret | input | 1 | Return-from-interrupt strobe |

## Verification
A flag that is stuck, or an enable that is decoded into the wrong bit, appears in `csr_rdata` one edge after the stimulus. The request is built from registered state without further delay, so a gating error shows on `irq_req` in that same cycle. Synchronizer or edge-detect faults show as a flag that arrives later than the third edge after a pin change, or that never arrives. A comparison value captured at the wrong time leaves bit 0 set after the port has been read.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
    parameter int PC_W = 4;

    typedef struct packed {
        logic gie;
        logic ee_en;
        logic tmr_en;
        logic ext_en;
        logic pc_en;
        logic tmr_f;
        logic ext_f;
        logic pc_f;
        logic ee_f;
    } irq_state_t;
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = async_i;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign sync_o = sy_q.s2;
endmodule

// File: rtl/irq_edge.sv
`timescale 1ns/1ps
module irq_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic evt_o
);
    logic prev_d, prev_q;

    always_comb prev_d = level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    generate
        if (RISING) begin : g_rise
            assign evt_o = level_i & ~prev_q;
        end else begin : g_fall
            assign evt_o = ~level_i & prev_q;
        end
    endgenerate
endmodule

// File: rtl/irq_pchg.sv
`timescale 1ns/1ps
module irq_pchg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_s,
    input  logic [W-1:0] dir_in,
    input  logic         rd_i,
    output logic         mismatch_o
);
    logic [W-1:0] lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (rd_i) lat_d = pins_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign mismatch_o = |((pins_s ^ lat_q) & dir_in);
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int          VEC_W    = 13,
    parameter int          VEC_ADDR = 4,
    parameter bit          EXT_RISE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_we,
    input  logic [7:0]       csr_wdata,
    output logic [7:0]       csr_rdata,
    input  logic             tmr_ovf,
    input  logic             ext_pin,
    input  logic [PC_W-1:0]  port_pins,
    input  logic [PC_W-1:0]  port_dir,
    input  logic             port_rd,
    input  logic             ee_done,
    input  logic             ee_flag_clr,
    output logic             ee_flag,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    input  logic             irq_ack,
    input  logic             irq_ret
);
    localparam int SYN_W = PC_W + 1;

    logic [SYN_W-1:0] syn_out;
    logic             ext_evt;
    logic             pc_hit;
    irq_state_t       st_d, st_q;

    irq_sync #(.W(SYN_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ext_pin, port_pins}),
        .sync_o  (syn_out)
    );

    irq_edge #(.RISING(EXT_RISE)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (syn_out[SYN_W-1]),
        .evt_o   (ext_evt)
    );

    irq_pchg #(.W(PC_W)) u_pchg (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_s     (syn_out[PC_W-1:0]),
        .dir_in     (port_dir),
        .rd_i       (port_rd),
        .mismatch_o (pc_hit)
    );

    always_comb begin
        st_d = st_q;
        if (csr_we) begin
            st_d.gie    = csr_wdata[7];
            st_d.ee_en  = csr_wdata[6];
            st_d.tmr_en = csr_wdata[5];
            st_d.ext_en = csr_wdata[4];
            st_d.pc_en  = csr_wdata[3];
            st_d.tmr_f  = st_q.tmr_f & csr_wdata[2];
            st_d.ext_f  = st_q.ext_f & csr_wdata[1];
            st_d.pc_f   = st_q.pc_f  & csr_wdata[0];
        end
        if (irq_ret) st_d.gie = 1'b1;
        if (irq_ack) st_d.gie = 1'b0;
        if (ee_flag_clr) st_d.ee_f = 1'b0;
        if (tmr_ovf) st_d.tmr_f = 1'b1;
        if (ext_evt) st_d.ext_f = 1'b1;
        if (pc_hit)  st_d.pc_f  = 1'b1;
        if (ee_done) st_d.ee_f  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign csr_rdata = {st_q.gie, st_q.ee_en, st_q.tmr_en, st_q.ext_en,
                        st_q.pc_en, st_q.tmr_f, st_q.ext_f, st_q.pc_f};
    assign ee_flag   = st_q.ee_f;
    assign irq_req   = st_q.gie & |{st_q.ee_en  & st_q.ee_f,
                                    st_q.tmr_en & st_q.tmr_f,
                                    st_q.ext_en & st_q.ext_f,
                                    st_q.pc_en  & st_q.pc_f};
    assign irq_vec   = VEC_W'(VEC_ADDR);
endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       csr_we,
    input logic [7:0] csr_rdata,
    input logic       tmr_ovf,
    input logic       ee_done,
    input logic       ee_flag,
    input logic       irq_req,
    input logic       irq_ack,
    input logic       irq_ret
);
    a_r3_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> csr_rdata[7]);

    a_r4_ack_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !csr_rdata[7]);

    a_r5_ret_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack) |=> csr_rdata[7]);

    a_r8_tmr_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> csr_rdata[2]);

    a_r6_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && !tmr_ovf && !csr_rdata[2]) |=> !csr_rdata[2]);

    a_r11_ee_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ee_done |=> ee_flag);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_rdata (csr_rdata),
    .tmr_ovf   (tmr_ovf),
    .ee_done   (ee_done),
    .ee_flag   (ee_flag),
    .irq_req   (irq_req),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret)
);

// File: tb/irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [7:0]  csr_wdata = '0;
    logic [7:0]  csr_rdata;
    logic        tmr_ovf = 1'b0;
    logic        ext_pin = 1'b0;
    logic [3:0]  port_pins = '0;
    logic [3:0]  port_dir = 4'hF;
    logic        port_rd = 1'b0;
    logic        ee_done = 1'b0;
    logic        ee_flag_clr = 1'b0;
    logic        ee_flag;
    logic        irq_req;
    logic [12:0] irq_vec;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin),
        .port_pins(port_pins), .port_dir(port_dir), .port_rd(port_rd),
        .ee_done(ee_done), .ee_flag_clr(ee_flag_clr), .ee_flag(ee_flag),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret)
    );

    // csr value to write, then expected irq_req after one timer pulse
    localparam logic [8:0] VEC [6] = '{
        {8'hA0, 1'b1}, {8'h20, 1'b0}, {8'h80, 1'b0},
        {8'hE0, 1'b1}, {8'h90, 1'b0}, {8'hB0, 1'b1}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        csr_we = 1'b1; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic tmr_pulse();
        tmr_ovf = 1'b1;
        @(negedge clk);
        tmr_ovf = 1'b0;
    endtask

    initial begin
        cyc_n(3);
        // R1 reset state
        chk("R1 rdata[7:1]", {9'd0, csr_rdata[7:1]}, 16'd0);
        chk("R1 irq_req", {15'd0, irq_req}, 16'd0);
        chk("R1 ee_flag", {15'd0, ee_flag}, 16'd0);
        rst_n = 1'b1;
        cyc_n(2);
        chk("R4 vector", {3'd0, irq_vec}, 16'h0004);

        // R2 R3 R8 gating table
        foreach (VEC[i]) begin
            wr(VEC[i][8:1]);
            chk("R2 enables", {8'd0, csr_rdata}, {8'd0, VEC[i][8:1]});
            tmr_pulse();
            chk("R8 timer flag", {15'd0, csr_rdata[2]}, 16'd1);
            chk("R3 irq_req", {15'd0, irq_req}, {15'd0, VEC[i][0]});
            wr(8'h00);
        end

        // R6 writing 1 to a flag does not set it; writing 0 clears
        wr(8'h07);
        chk("R6 no sw set", {13'd0, csr_rdata[2:0]}, 16'd0);
        tmr_pulse();
        wr(8'h04);
        chk("R6 write 1 keeps", {15'd0, csr_rdata[2]}, 16'd1);
        wr(8'h00);
        chk("R6 write 0 clears", {15'd0, csr_rdata[2]}, 16'd0);

        // R7 set wins over clear
        tmr_ovf = 1'b1; csr_we = 1'b1; csr_wdata = 8'h00;
        @(negedge clk);
        tmr_ovf = 1'b0; csr_we = 1'b0;
        chk("R7 set wins", {15'd0, csr_rdata[2]}, 16'd1);

        // R4 R5 taken and return
        wr(8'hA4);
        chk("R3 req pending", {15'd0, irq_req}, 16'd1);
        irq_ack = 1'b1; irq_ret = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0; irq_ret = 1'b0;
        chk("R4 ack clears gie", {15'd0, csr_rdata[7]}, 16'd0);
        chk("R4 req dropped", {15'd0, irq_req}, 16'd0);
        irq_ret = 1'b1; csr_we = 1'b1; csr_wdata = 8'h24;
        @(negedge clk);
        irq_ret = 1'b0; csr_we = 1'b0;
        chk("R5 ret sets gie", {15'd0, csr_rdata[7]}, 16'd1);
        chk("R5 retrigger", {15'd0, irq_req}, 16'd1);
        wr(8'h00);

        // R9 external pin edges
        wr(8'h90);
        ext_pin = 1'b1;
        cyc_n(4);
        chk("R9 rising sets", {15'd0, csr_rdata[1]}, 16'd1);
        chk("R9 req", {15'd0, irq_req}, 16'd1);
        wr(8'h00);
        ext_pin = 1'b0;
        cyc_n(4);
        chk("R9 falling ignored", {15'd0, csr_rdata[1]}, 16'd0);

        // R10 port change
        port_dir = 4'b0111;
        port_pins = 4'b1000;
        cyc_n(4);
        chk("R10 output pin ignored", {15'd0, csr_rdata[0]}, 16'd0);
        port_pins = 4'b1010;
        cyc_n(4);
        chk("R10 input change sets", {15'd0, csr_rdata[0]}, 16'd1);
        wr(8'h00);
        chk("R10 mismatch holds", {15'd0, csr_rdata[0]}, 16'd1);
        port_rd = 1'b1;
        @(negedge clk);
        port_rd = 1'b0;
        cyc_n(1);
        wr(8'h00);
        chk("R10 cleared after read", {15'd0, csr_rdata[0]}, 16'd0);

        // R11 EEPROM completion
        wr(8'h80);
        ee_done = 1'b1;
        @(negedge clk);
        ee_done = 1'b0;
        chk("R11 ee set", {15'd0, ee_flag}, 16'd1);
        chk("R3 ee gated by bit6", {15'd0, irq_req}, 16'd0);
        wr(8'hC0);
        chk("R3 ee enabled", {15'd0, irq_req}, 16'd1);
        ee_done = 1'b1; ee_flag_clr = 1'b1;
        @(negedge clk);
        ee_done = 1'b0;
        chk("R11 set wins", {15'd0, ee_flag}, 16'd1);
        @(negedge clk);
        ee_flag_clr = 1'b0;
        chk("R11 clear", {15'd0, ee_flag}, 16'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule